// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Walker

This block moves a requested number of bytes between a device-side buffer and a set of memory regions listed in a descriptor table. An upstream register file supplies a start pulse, the table's base address, the byte count and the transfer direction. The walker then reads 8-byte descriptors one at a time through a read-only fetch port. Each descriptor gives it a region address, a region length and an end-of-table flag. It issues one burst request per region, or per part of a region, to a memory port.

Each burst covers as many bytes as both the remaining request and the remaining region allow. The walk finishes in one of two ways. If the full count has moved, the block pulses `done`. If the table ends first, it pulses `done` together with `short_err`. The table ends either at a descriptor carrying the end flag, or when the table pointer has gone one page (4096 bytes) past the base. The page limit keeps a malformed table from sending the walker through unbounded memory.

Top module: `sg_walker`

## Requirements
- R1: A synchronous reset (`rst` high) returns the block to idle. After reset, `busy`, `done`, `short_err`, `fd_valid` and `bu_valid` are all low.
- R2: A fetch at `fd_addr` returns a 64-bit descriptor on `fd_data`. Bits [31:0] hold the region address. The region length is bits [47:32] with bit 32 forced to zero, so odd counts round down to even. Bit 63 is the end-of-table flag.
- R3: A masked length field of zero means a region of 65536 bytes.
- R4: The first fetch after a start reads at `tbl_base`. Each later fetch reads 8 bytes above the previous one.
- R5: Each burst has `bu_len` equal to the smaller of the bytes still requested and the bytes left in the current region. The next burst in the same region starts at `bu_addr` plus that length.
- R6: Suppose a region whose descriptor has bit 63 set is used up while bytes are still requested. The block then pulses `done` with `short_err` and fetches nothing further.
- R7: A descriptor is fetched only while `fd_addr - tbl_base` is below 4096. When another descriptor is needed and the pointer is 4096 or more past the base, the walk ends with `done` and `short_err`.
- R8: `bu_write` equals the `to_mem` value captured at start. The value 1 means memory is written from the device buffer; the value 0 means memory is read into it.
- R9: While `fd_valid` or `bu_valid` is high and the matching ready is low, the request and its address, length and direction stay unchanged. At most one of the two requests is active at a time.
- R10: `done` is a one-cycle pulse, and `busy` is low while it is high. `short_err` is high only together with `done`. When the full count is moved, `done` comes without `short_err`, even if the current region still has bytes left.
- R11: A start clears the current region state and reloads the table pointer from `tbl_base`. A new walk therefore refetches from the base and never continues a region left over from the previous walk.
- R12: A start while `busy` is high is ignored. A start with `req_bytes` of zero gives `done` without `short_err` and issues no fetch or burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only while idle |
| tbl_base | input | ADDR_W | Base address of the descriptor table |
| req_bytes | input | CNT_W | Number of bytes to move |
| to_mem | input | 1 | Direction: 1 = device buffer to memory, 0 = memory to device buffer |
| fd_valid | output | 1 | Descriptor fetch request |
| fd_addr | output | ADDR_W | Descriptor address |
| fd_ready | input | 1 | Fetch accepted; `fd_data` is valid in the same cycle |
| fd_data | input | 64 | Descriptor contents |
| bu_valid | output | 1 | Burst request |
| bu_addr | output | ADDR_W | Burst start address in memory |
| bu_len | output | 17 | Burst length in bytes (1 to 65536) |
| bu_write | output | 1 | Burst direction, 1 = write to memory |
| bu_ready | input | 1 | Burst accepted |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| short_err | output | 1 | The table ended before the count was moved (valid with `done`) |

## Verification
Some properties are checked on every cycle by assertions:
- requests hold steady while stalled, and only one request is active at a time;
- burst lengths stay in the range 1 to 65536;
- no fetch is made at or beyond one page past the base;
- `done` is a single-cycle pulse, `short_err` never appears without `done`, and `done` never appears while busy.

Other behaviour only the directed scenarios can show, by comparing the logged fetch addresses and burst sequence against a walk computed in the bench:
- descriptor decoding and the 64K length encoding;
- splitting a request across regions;
- early termination at the end flag and at the page limit;
- direction capture;
- a restart reloading from the base;
- a start ignored while busy.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  // A region length is a 16-bit field whose zero value means 64K, so 17 bits hold it.
  localparam int unsigned REGION_LEN_W = 17;
  localparam int unsigned DESC_W       = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_FETCH = 2'd2,
    ST_BURST = 2'd3
  } sgw_state_e;

  // Masked length field; a zero field is a full 64K region.
  function automatic logic [REGION_LEN_W-1:0] region_len(input logic [15:0] field);
    logic [15:0] even;
    even = {field[15:1], 1'b0};
    return (even == 16'd0) ? 17'h10000 : {1'b0, even};
  endfunction

endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [DESC_W-1:0]       raw,
  output logic [ADDR_W-1:0]       reg_addr,
  output logic [REGION_LEN_W-1:0] reg_len,
  output logic                    reg_last
);
  // Low word: region address. High word: count in [15:0], end flag in bit 31.
  assign reg_addr = raw[ADDR_W-1:0];
  assign reg_len  = region_len(raw[47:32]);
  assign reg_last = raw[63];

  logic unused_fields;
  assign unused_fields = &{1'b0, raw[62:48]};
endmodule

// File: rtl/sgw_table_guard.sv
module sgw_table_guard #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] offset,
  output logic              exhausted
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(PAGE_BYTES);

  assign offset    = ptr - base;
  assign exhausted = (offset >= LIMIT);
endmodule

// File: rtl/sgw_burst_size.sv
module sgw_burst_size #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned LEN_W = 17
) (
  input  logic [CNT_W-1:0] remaining,
  input  logic [LEN_W-1:0] region_left,
  output logic [LEN_W-1:0] size
);
  localparam int unsigned W = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [W-1:0] rem_ext;
  logic [W-1:0] left_ext;

  assign rem_ext  = W'(remaining);
  assign left_ext = W'(region_left);
  assign size     = (rem_ext < left_ext) ? LEN_W'(rem_ext) : region_left;
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       tbl_base,
  input  logic [CNT_W-1:0]        req_bytes,
  input  logic                    to_mem,
  output logic                    fd_valid,
  output logic [ADDR_W-1:0]       fd_addr,
  input  logic                    fd_ready,
  input  logic [DESC_W-1:0]       fd_data,
  output logic                    bu_valid,
  output logic [ADDR_W-1:0]       bu_addr,
  output logic [REGION_LEN_W-1:0] bu_len,
  output logic                    bu_write,
  input  logic                    bu_ready,
  output logic                    busy,
  output logic                    done,
  output logic                    short_err
);
  localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(DESC_BYTES);

  sgw_state_e              state_q;
  logic [ADDR_W-1:0]       base_q;
  logic [ADDR_W-1:0]       ptr_q;
  logic [CNT_W-1:0]        rem_q;
  logic [ADDR_W-1:0]       cur_addr_q;
  logic [REGION_LEN_W-1:0] cur_len_q;
  logic                    cur_last_q;
  logic                    dir_q;
  logic                    done_q;
  logic                    short_q;

  // Decoded descriptor
  logic [ADDR_W-1:0]       dec_addr;
  logic [REGION_LEN_W-1:0] dec_len;
  logic                    dec_last;

  // Table pointer guard
  logic [ADDR_W-1:0]       tbl_off;
  logic                    tbl_exhausted;

  // Burst size
  logic [REGION_LEN_W-1:0] burst_len;

  sgw_desc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .raw      (fd_data),
    .reg_addr (dec_addr),
    .reg_len  (dec_len),
    .reg_last (dec_last)
  );

  sgw_table_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_guard (
    .ptr       (ptr_q),
    .base      (base_q),
    .offset    (tbl_off),
    .exhausted (tbl_exhausted)
  );

  sgw_burst_size #(.CNT_W(CNT_W), .LEN_W(REGION_LEN_W)) u_size (
    .remaining   (rem_q),
    .region_left (cur_len_q),
    .size        (burst_len)
  );

  // Named internal events, exposed for the checker.
  logic ev_start, ev_fetch, ev_burst, ev_finish_ok, ev_finish_short, ev_need_fetch;
  logic region_empty;

  assign region_empty    = (cur_len_q == '0);
  assign ev_start        = (state_q == ST_IDLE) && start;
  assign ev_fetch        = (state_q == ST_FETCH) && fd_ready;
  assign ev_burst        = (state_q == ST_BURST) && bu_ready;
  assign ev_finish_ok    = (state_q == ST_CHECK) && (rem_q == '0);
  assign ev_finish_short = (state_q == ST_CHECK) && (rem_q != '0) && region_empty &&
                           (cur_last_q || tbl_exhausted);
  assign ev_need_fetch   = (state_q == ST_CHECK) && (rem_q != '0) && region_empty &&
                           !cur_last_q && !tbl_exhausted;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      ptr_q      <= '0;
      rem_q      <= '0;
      cur_addr_q <= '0;
      cur_len_q  <= '0;
      cur_last_q <= 1'b0;
      dir_q      <= 1'b0;
      done_q     <= 1'b0;
      short_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      short_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ev_start) begin
            base_q     <= tbl_base;
            ptr_q      <= tbl_base;
            rem_q      <= req_bytes;
            dir_q      <= to_mem;
            cur_addr_q <= '0;
            cur_len_q  <= '0;
            cur_last_q <= 1'b0;
            state_q    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (ev_finish_ok || ev_finish_short) begin
            done_q  <= 1'b1;
            short_q <= ev_finish_short;
            state_q <= ST_IDLE;
          end else if (ev_need_fetch) begin
            state_q <= ST_FETCH;
          end else begin
            state_q <= ST_BURST;
          end
        end
        ST_FETCH: begin
          if (ev_fetch) begin
            cur_addr_q <= dec_addr;
            cur_len_q  <= dec_len;
            cur_last_q <= dec_last;
            ptr_q      <= ptr_q + PTR_STEP;
            state_q    <= ST_CHECK;
          end
        end
        ST_BURST: begin
          if (ev_burst) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(burst_len);
            cur_len_q  <= cur_len_q - burst_len;
            rem_q      <= rem_q - CNT_W'(burst_len);
            state_q    <= ST_CHECK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fd_valid  = (state_q == ST_FETCH);
  assign fd_addr   = ptr_q;
  assign bu_valid  = (state_q == ST_BURST);
  assign bu_addr   = cur_addr_q;
  assign bu_len    = burst_len;
  assign bu_write  = dir_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign short_err = short_q;

endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              short_err,
  input logic              fd_valid,
  input logic              fd_ready,
  input logic [ADDR_W-1:0] fd_addr,
  input logic              bu_valid,
  input logic              bu_ready,
  input logic [ADDR_W-1:0] bu_addr,
  input logic [16:0]       bu_len,
  input logic              bu_write,
  input logic [ADDR_W-1:0] tbl_off
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(PAGE_BYTES);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !short_err && !fd_valid && !bu_valid));

  a_r9_burst_hold: assert property (@(posedge clk) disable iff (rst)
    (bu_valid && !bu_ready) |=> (bu_valid && $stable(bu_addr) && $stable(bu_len) && $stable(bu_write)));

  a_r9_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    (fd_valid && !fd_ready) |=> (fd_valid && $stable(fd_addr)));

  a_r9_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fd_valid, bu_valid}));

  a_r5_burst_len_range: assert property (@(posedge clk) disable iff (rst)
    bu_valid |-> (bu_len != 17'd0 && bu_len <= 17'h10000));

  a_r7_fetch_in_page: assert property (@(posedge clk) disable iff (rst)
    fd_valid |-> (tbl_off < LIMIT));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_short_with_done: assert property (@(posedge clk) disable iff (rst)
    short_err |-> done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind sg_walker sg_walker_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .short_err (short_err),
  .fd_valid  (fd_valid),
  .fd_ready  (fd_ready),
  .fd_addr   (fd_addr),
  .bu_valid  (bu_valid),
  .bu_ready  (bu_ready),
  .bu_addr   (bu_addr),
  .bu_len    (bu_len),
  .bu_write  (bu_write),
  .tbl_off   (tbl_off)
);

// File: tb/sg_walker_tb_top.sv
`timescale 1ns/1ps
module sg_walker_tb_top;
  localparam int TBL_N = 600;
  localparam int MAXB  = 700;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [23:0] req_bytes = '0;
  logic        to_mem = 1'b0;
  logic        fd_valid;
  logic [31:0] fd_addr;
  logic        fd_ready = 1'b0;
  logic [63:0] fd_data = '0;
  logic        bu_valid;
  logic [31:0] bu_addr;
  logic [16:0] bu_len;
  logic        bu_write;
  logic        bu_ready = 1'b0;
  logic        busy, done, short_err;

  always #2 clk = ~clk;

  sg_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .tbl_base(tbl_base), .req_bytes(req_bytes),
    .to_mem(to_mem), .fd_valid(fd_valid), .fd_addr(fd_addr), .fd_ready(fd_ready),
    .fd_data(fd_data), .bu_valid(bu_valid), .bu_addr(bu_addr), .bu_len(bu_len),
    .bu_write(bu_write), .bu_ready(bu_ready), .busy(busy), .done(done), .short_err(short_err)
  );

  // Memory image of the table, indexed by descriptor slot from the current base.
  logic [31:0] tw0 [TBL_N];
  logic [31:0] tw1 [TBL_N];
  logic [31:0] mem_base = '0;

  // Observed activity
  int          n_fetch, n_burst, fetch_bad, dir_bad, hold_bad, done_cnt, done_long, orphan_short;
  logic        last_short;
  logic        exp_dir;
  longint      log_addr [MAXB];
  longint      log_len  [MAXB];

  // Expected walk
  int          e_n, e_fetch;
  logic        e_short;
  longint      e_addr [MAXB];
  longint      e_len  [MAXB];

  int          total = 0;
  int          bad = 0;
  int unsigned tick = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Responder and monitor, all on the falling edge.
  initial begin
    logic        pbv, pbr, pfv, pfr, pdone;
    logic [31:0] pba, pfa;
    logic [16:0] pbl;
    pbv = 0; pbr = 0; pfv = 0; pfr = 0; pdone = 0; pba = 0; pfa = 0; pbl = 0;
    forever begin
      @(negedge clk);
      tick++;
      if (bu_valid && pbv && !pbr && (bu_addr != pba || bu_len != pbl)) hold_bad++;
      if (fd_valid && pfv && !pfr && fd_addr != pfa) hold_bad++;
      if (done) begin
        done_cnt++;
        last_short = short_err;
        if (pdone) done_long++;
      end
      if (short_err && !done) orphan_short++;
      pdone = done;
      if (fd_valid && (tick % 4 != 1)) begin
        int idx;
        idx = int'((fd_addr - mem_base) >> 3);
        if (fd_addr != mem_base + 32'(8 * n_fetch)) fetch_bad++;
        fd_data = (idx >= 0 && idx < TBL_N) ? {tw1[idx], tw0[idx]} : 64'h8000_0002_0000_0000;
        fd_ready = 1'b1;
        n_fetch++;
      end else begin
        fd_ready = 1'b0;
      end
      if (bu_valid && (tick % 3 != 0)) begin
        if (n_burst < MAXB) begin
          log_addr[n_burst] = longint'(bu_addr);
          log_len[n_burst]  = longint'(bu_len);
        end
        if (bu_write != exp_dir) dir_bad++;
        n_burst++;
        bu_ready = 1'b1;
      end else begin
        bu_ready = 1'b0;
      end
      pbv = bu_valid; pbr = bu_ready; pba = bu_addr; pbl = bu_len;
      pfv = fd_valid; pfr = fd_ready; pfa = fd_addr;
    end
  end

  task automatic clear_table();
    for (int i = 0; i < TBL_N; i++) begin
      tw0[i] = '0;
      tw1[i] = '0;
    end
  endtask

  // Walk the table the way the requirements describe it.
  task automatic model(input longint req);
    longint rem, left, ra, l;
    int     slot;
    logic   lastf;
    rem = req; left = 0; ra = 0; slot = 0; lastf = 0;
    e_n = 0; e_fetch = 0; e_short = 0;
    while (rem > 0) begin
      if (left == 0) begin
        if (lastf || slot * 8 >= 4096) begin
          e_short = 1;
          break;
        end
        ra    = longint'(tw0[slot]);
        left  = longint'(tw1[slot][15:0] & 16'hFFFE);
        if (left == 0) left = 65536;
        lastf = tw1[slot][31];
        slot++;
        e_fetch++;
      end
      l = (rem < left) ? rem : left;
      if (e_n < MAXB) begin
        e_addr[e_n] = ra;
        e_len[e_n]  = l;
      end
      e_n++;
      ra   = (ra + l) & 64'hFFFF_FFFF;
      left = left - l;
      rem  = rem - l;
    end
  endtask

  task automatic launch(input logic [31:0] b, input logic [23:0] req, input logic dir);
    n_fetch = 0; n_burst = 0; fetch_bad = 0; dir_bad = 0;
    exp_dir = dir;
    mem_base = b;
    @(negedge clk);
    tbl_base = b; req_bytes = req; to_mem = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0, output bit got);
    got = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #1;
      if (done_cnt != d0) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic compare(input string tag);
    int mis;
    mis = 0;
    chk(n_burst == e_n, {tag, " burst count"}, n_burst, e_n);
    for (int i = 0; i < e_n && i < n_burst && i < MAXB; i++)
      if (log_addr[i] != e_addr[i] || log_len[i] != e_len[i]) mis++;
    chk(mis == 0, {tag, " burst addr/len"}, mis, 0);
    chk(n_fetch == e_fetch, {tag, " fetch count"}, n_fetch, e_fetch);
    chk(fetch_bad == 0, {tag, " R4 fetch address step"}, fetch_bad, 0);
    chk(last_short == e_short, {tag, " short flag"}, last_short, e_short);
    chk(dir_bad == 0, {tag, " R8 direction"}, dir_bad, 0);
  endtask

  task automatic run_walk(input string tag, input logic [31:0] b, input logic [23:0] req,
                          input logic dir);
    int d0;
    bit got;
    model(longint'(req));
    d0 = done_cnt;
    launch(b, req, dir);
    wait_done(d0, got);
    chk(got, {tag, " done seen"}, got, 1);
    compare(tag);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !short_err, "R1 idle outputs after reset", {busy, done, short_err}, 0);
    chk(!fd_valid && !bu_valid, "R1 no requests after reset", {fd_valid, bu_valid}, 0);
  endtask

  task automatic t_basic();  // R2 R4 R5 R8: three regions, exact fit, write direction
    clear_table();
    tw0[0] = 32'h8000_0000; tw1[0] = 32'h0000_0100;
    tw0[1] = 32'h8000_2000; tw1[1] = 32'h0000_0040;
    tw0[2] = 32'h9000_0000; tw1[2] = 32'h8000_0020;
    run_walk("R2 basic", 32'h0000_1000, 24'h160, 1'b1);
  endtask

  task automatic t_big();  // R3 zero field is 64K, R2 odd count rounds down, read direction
    clear_table();
    tw0[0] = 32'h0000_0010; tw1[0] = 32'h0000_0000;
    tw0[1] = 32'h0004_0000; tw1[1] = 32'h8000_0101;
    run_walk("R3 64K region", 32'h0000_2000, 24'd65600, 1'b0);
    chk(log_len[0] == 65536, "R3 first burst length", log_len[0], 65536);
  endtask

  task automatic t_early_last();  // R6
    clear_table();
    tw0[0] = 32'h0000_7000; tw1[0] = 32'h8000_0080;
    tw0[1] = 32'h0000_9000; tw1[1] = 32'h0000_0080;
    run_walk("R6 early end", 32'h0000_3000, 24'h200, 1'b1);
    chk(last_short == 1'b1, "R6 short reported", last_short, 1);
  endtask

  task automatic t_partial();  // R5 R10 count ends inside a region
    clear_table();
    tw0[0] = 32'h0000_5000; tw1[0] = 32'h8000_1000;
    run_walk("R10 partial region", 32'h0000_4000, 24'h30, 1'b0);
    chk(last_short == 1'b0, "R10 no short when count met", last_short, 0);
  endtask

  task automatic t_restart();  // R11 same table after a leftover region
    run_walk("R11 restart", 32'h0000_4000, 24'h50, 1'b1);
    chk(log_addr[0] == 64'h5000, "R11 region restarts at its base", log_addr[0], 64'h5000);
  endtask

  task automatic t_guard();  // R7 unterminated table
    clear_table();
    for (int i = 0; i < TBL_N; i++) begin
      tw0[i] = 32'h0010_0000 + 32'(i * 16);
      tw1[i] = 32'h0000_0002;
    end
    run_walk("R7 page guard", 32'h0000_0000, 24'd5000, 1'b1);
    chk(n_fetch == 512, "R7 fetches within one page", n_fetch, 512);
  endtask

  task automatic t_zero();  // R12 zero request
    clear_table();
    tw0[0] = 32'h0000_1234; tw1[0] = 32'h8000_0010;
    run_walk("R12 zero request", 32'h0000_6000, 24'd0, 1'b0);
  endtask

  task automatic t_busy_start();  // R12 start while busy
    int  d0;
    bit  got;
    clear_table();
    tw0[0] = 32'h0000_a000; tw1[0] = 32'h0000_0010;
    tw0[1] = 32'h0000_b000; tw1[1] = 32'h8000_0010;
    model(64'h20);
    d0 = done_cnt;
    launch(32'h0000_7000, 24'h20, 1'b1);
    repeat (3) @(negedge clk);
    tbl_base = 32'h0000_0100; req_bytes = 24'h999; to_mem = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(d0, got);
    chk(got, "R12 busy start done seen", got, 1);
    compare("R12 busy start");
    repeat (20) @(negedge clk);
    chk(done_cnt == d0 + 1, "R12 single completion", done_cnt - d0, 1);
    chk(!busy, "R12 idle after walk", busy, 0);
  endtask

  initial begin
    n_fetch = 0; n_burst = 0; fetch_bad = 0; dir_bad = 0; hold_bad = 0;
    done_cnt = 0; done_long = 0; orphan_short = 0; last_short = 0; exp_dir = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_big();
    t_early_last();
    t_partial();
    t_restart();
    t_guard();
    t_zero();
    t_busy_start();
    chk(hold_bad == 0, "R9 request hold while stalled", hold_bad, 0);
    chk(done_long == 0, "R10 done one cycle", done_long, 0);
    chk(orphan_short == 0, "R10 short only with done", orphan_short, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule